// File: doc/BRIEF.md
# Decrement-and-Branch Loop Unit

This block executes the loop-closing instruction of a small processor core. The sequencer presents the fetched opcode byte together with the displacement byte, the current value of the 8-bit loop counter and the address of the next instruction, and raises `op_valid`. When the opcode is the loop instruction, the unit decrements the counter and tests the decremented value. If that value is nonzero, it adds the sign-extended displacement to the next-instruction address. If it is zero, execution falls through to the next instruction.

One clock after acceptance the unit pulses `res_valid` for one cycle. In that cycle it presents the new counter value, the new program counter, a taken flag and the number of cycles the sequencer must charge for the instruction. The PC adder has two modes. In long-address mode it works on the full 24-bit address. In short mode it wraps within the low 16 bits and leaves the top byte unchanged. No condition flags are read or written.

Top module: `loop_branch_unit`

## Requirements
- R1: After a synchronous active-low reset, `res_valid`, `br_taken`, `cnt_out`, `pc_out` and `cyc_count` are all zero.
- R2: When `op_valid` is high and `opcode` equals 0x10 at a rising edge, `res_valid` is high for exactly the following clock cycle.
- R3: An `op_valid` with any other opcode byte is ignored: `res_valid` stays low and every result output keeps its previous value.
- R4: `cnt_out` equals `cnt_in` minus one, modulo 256.
- R5: `br_taken` is 1 exactly when the decremented count is nonzero. A count of 0x01 falls through, and a count of 0x00 wraps to 0xFF and branches.
- R6: When the branch is taken in long mode (`long_mode`=1), `pc_out` equals `next_pc` plus the two's-complement displacement, sign-extended, modulo 2^24.
- R7: When the branch is taken in short mode (`long_mode`=0), `pc_out[15:0]` equals `next_pc[15:0]` plus the sign-extended displacement modulo 2^16, and `pc_out[23:16]` equals `next_pc[23:16]`.
- R8: When the branch is not taken, `pc_out` equals `next_pc` in either mode.
- R9: `cyc_count` is 2 for a fall-through and 4 for a taken branch.
- R10: While no loop instruction is accepted, all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Instruction bytes and operands are present |
| opcode | input | 8 | Fetched opcode byte |
| disp | input | 8 | Two's-complement displacement byte |
| cnt_in | input | 8 | Current loop counter value |
| next_pc | input | 24 | Address of the instruction after the two-byte loop instruction |
| long_mode | input | 1 | 1: 24-bit address arithmetic; 0: 16-bit wrapping |
| res_valid | output | 1 | One-cycle pulse marking valid results |
| cnt_out | output | 8 | Decremented counter value |
| pc_out | output | 24 | New program counter |
| br_taken | output | 1 | Branch was taken |
| cyc_count | output | 3 | Cycle charge for the sequencer |

## Verification
The bench targets the counter edges. A count of 0x01 must fall through, and a design that tested the count before decrementing would branch there instead. A count of 0x00 must wrap to 0xFF and branch, which a saturating or pre-test design gets wrong. The displacement edges are also covered. A displacement of 0x80 or 0xFE must move the PC backward, so zero-extension shows up as a forward jump. The bench carries PC sums across the 16-bit and 24-bit limits in each mode, where a wrong adder width either spills into the top byte or fails to wrap. It also drives a neighbouring opcode, so a loose decode would produce a stray result pulse or change the held outputs.

// File: rtl/lbu_pkg.sv
// Package: shared widths, the loop opcode, cycle charges and the result record.
// Assumes: a single byte-wide opcode identifies the loop instruction.
package lbu_pkg;
    parameter int CNT_W   = 8;
    parameter int DISP_W  = 8;
    parameter int PC_W    = 24;
    parameter int SHORT_W = 16;
    parameter int CYC_W   = 3;
    parameter int OP_W    = 8;

    localparam logic [OP_W-1:0]  LOOP_OPCODE = 8'h10;
    localparam logic [CYC_W-1:0] CYC_FALL    = 3'd2;
    localparam logic [CYC_W-1:0] CYC_TAKEN   = 3'd4;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [PC_W-1:0]  pc;
        logic             taken;
        logic [CYC_W-1:0] cycles;
    } lbu_result_t;
endpackage

// File: rtl/lbu_counter_step.sv
// Module: decrements the loop counter and flags a nonzero result.
// Assumes: the counter wraps modulo 2^W; the test uses the decremented value.
module lbu_counter_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt_in,
    output logic [W-1:0] cnt_next,
    output logic         nonzero
);
    localparam logic [W-1:0] ONE = W'(1);

    // Decrement then test the new value.
    always_comb begin
        cnt_next = cnt_in - ONE;
        nonzero  = |cnt_next;
    end
endmodule

// File: rtl/lbu_target_calc.sv
// Module: forms the branch target from the next-instruction address and a
// signed displacement, in full-width or short (wrapped) arithmetic.
// Assumes: PC_W >= SHORT_W >= DISP_W; short mode keeps the top bits of base.
module lbu_target_calc #(
    parameter int PC_W    = 24,
    parameter int SHORT_W = 16,
    parameter int DISP_W  = 8
) (
    input  logic [PC_W-1:0]   base,
    input  logic [DISP_W-1:0] disp,
    input  logic              wide,
    output logic [PC_W-1:0]   target
);
    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0]    disp_sx;
    logic [PC_W-1:0]    sum_full;
    logic [SHORT_W-1:0] sum_short;
    logic [PC_W-1:0]    short_target;

    // Sign-extend the displacement and form both sums.
    always_comb begin
        disp_sx   = {{EXT_W{disp[DISP_W-1]}}, disp};
        sum_full  = base + disp_sx;
        sum_short = base[SHORT_W-1:0] + disp_sx[SHORT_W-1:0];
    end

    // Short result: keep the upper bits of the base when they exist.
    generate
        if (PC_W > SHORT_W) begin : g_keep_upper
            assign short_target = {base[PC_W-1:SHORT_W], sum_short};
        end else begin : g_no_upper
            assign short_target = sum_short;
        end
    endgenerate

    // Select the arithmetic width.
    always_comb target = wide ? sum_full : short_target;
endmodule

// File: rtl/lbu_cycle_sel.sv
// Module: maps the branch decision to the cycle charge for the sequencer.
// Assumes: a taken branch costs more cycles than a fall-through.
module lbu_cycle_sel
    import lbu_pkg::*;
(
    input  logic             taken,
    output logic [CYC_W-1:0] cycles
);
    // Pick the charge for the decision.
    always_comb cycles = taken ? CYC_TAKEN : CYC_FALL;
endmodule

// File: rtl/loop_branch_unit.sv
// Module: decrement-and-branch loop unit. Accepts the loop instruction when
// op_valid is high with the matching opcode, and registers the new counter,
// the new PC, the taken flag and the cycle charge. res_valid pulses one
// cycle after acceptance. Results hold until the next accepted instruction.
// Assumes: synchronous active-low reset; next_pc already points past the
// two-byte instruction.
module loop_branch_unit
    import lbu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DISP_W-1:0] disp,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [PC_W-1:0]   next_pc,
    input  logic              long_mode,
    output logic              res_valid,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [PC_W-1:0]   pc_out,
    output logic              br_taken,
    output logic [CYC_W-1:0]  cyc_count
);
    logic             accept;
    logic [CNT_W-1:0] cnt_next;
    logic             cnt_nz;
    logic [PC_W-1:0]  target;
    logic [CYC_W-1:0] cycles;
    lbu_result_t      res_d;
    lbu_result_t      res_q;
    logic             valid_q;

    // Decode the loop instruction.
    always_comb accept = op_valid && (opcode == LOOP_OPCODE);

    lbu_counter_step #(.W(CNT_W)) u_count (
        .cnt_in   (cnt_in),
        .cnt_next (cnt_next),
        .nonzero  (cnt_nz)
    );

    lbu_target_calc #(.PC_W(PC_W), .SHORT_W(SHORT_W), .DISP_W(DISP_W)) u_target (
        .base   (next_pc),
        .disp   (disp),
        .wide   (long_mode),
        .target (target)
    );

    lbu_cycle_sel u_cycles (
        .taken  (cnt_nz),
        .cycles (cycles)
    );

    // Assemble the next result record.
    always_comb begin
        res_d.count  = cnt_next;
        res_d.pc     = cnt_nz ? target : next_pc;
        res_d.taken  = cnt_nz;
        res_d.cycles = cycles;
    end

    // Register results on acceptance; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= accept;
            if (accept) res_q <= res_d;
        end
    end

    // Drive the ports from the result register.
    always_comb begin
        res_valid = valid_q;
        cnt_out   = res_q.count;
        pc_out    = res_q.pc;
        br_taken  = res_q.taken;
        cyc_count = res_q.cycles;
    end

    // R2: a result pulse follows a matching instruction.
    a_r2_valid_follows_op: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(op_valid) && ($past(opcode) == LOOP_OPCODE));

    // R4: counter output is the input minus one.
    a_r4_count_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> cnt_out == CNT_W'($past(cnt_in) - CNT_W'(1)));

    // R5: taken only with a nonzero new count.
    a_r5_taken_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (br_taken == (cnt_out != '0)));

    // R8: a fall-through leaves the PC at the next address.
    a_r8_fall_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !br_taken) |-> pc_out == $past(next_pc));

    // R9: cycle charge matches the decision.
    a_r9_cycle_charge: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> cyc_count == (br_taken ? CYC_TAKEN : CYC_FALL));

    // R10: results hold without a result pulse.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && $past(rst_n)) |-> $stable(pc_out) && $stable(cnt_out));
endmodule

// File: tb/loop_branch_unit_bench.sv
// Bench: directed scenarios for the loop unit, one task each.
module loop_branch_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  disp = 8'h00;
    logic [7:0]  cnt_in = 8'h00;
    logic [23:0] next_pc = 24'h0;
    logic        long_mode = 1'b1;
    logic        res_valid;
    logic [7:0]  cnt_out;
    logic [23:0] pc_out;
    logic        br_taken;
    logic [2:0]  cyc_count;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    loop_branch_unit u_loop_branch_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .disp(disp), .cnt_in(cnt_in), .next_pc(next_pc), .long_mode(long_mode),
        .res_valid(res_valid), .cnt_out(cnt_out), .pc_out(pc_out),
        .br_taken(br_taken), .cyc_count(cyc_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_pc(input logic [7:0] c, input logic [7:0] d,
                                           input logic [23:0] p, input logic w);
        logic [23:0] sx;
        logic [15:0] lo;
        sx = {{16{d[7]}}, d};
        if (c == 8'h01) return p;
        if (w) return p + sx;
        lo = p[15:0] + sx[15:0];
        return {p[23:16], lo};
    endfunction

    // One loop instruction; checks the pulse, results and the hold after it.
    task automatic run_loop(input string tag, input logic [7:0] c, input logic [7:0] d,
                            input logic [23:0] p, input logic w);
        logic [7:0]  ec;
        logic        et;
        logic [23:0] ep;
        ec = c - 8'h01;
        et = (ec != 8'h00);
        ep = exp_pc(c, d, p, w);
        @(negedge clk);
        op_valid = 1'b1; opcode = 8'h10; disp = d; cnt_in = c; next_pc = p; long_mode = w;
        @(negedge clk);
        op_valid = 1'b0;
        check({tag, " R2 valid"}, 32'(res_valid), 32'd1);
        check({tag, " R4 count"}, 32'(cnt_out), 32'(ec));
        check({tag, " R5 taken"}, 32'(br_taken), 32'(et));
        check({tag, w ? " R6/R8 pc" : " R7/R8 pc"}, 32'(pc_out), 32'(ep));
        check({tag, " R9 cycles"}, 32'(cyc_count), et ? 32'd4 : 32'd2);
        cnt_in = 8'h55; next_pc = 24'hABCDEF;
        @(negedge clk);
        check({tag, " R2 one-cycle pulse"}, 32'(res_valid), 32'd0);
        check({tag, " R10 hold pc"}, 32'(pc_out), 32'(ep));
    endtask

    // A non-loop opcode must not disturb anything.
    task automatic run_ignored();
        logic [23:0] pc_before;
        logic [7:0]  cnt_before;
        pc_before = pc_out; cnt_before = cnt_out;
        @(negedge clk);
        op_valid = 1'b1; opcode = 8'h11; disp = 8'h7F; cnt_in = 8'h09; next_pc = 24'h000100;
        @(negedge clk);
        op_valid = 1'b0;
        check("R3 no pulse", 32'(res_valid), 32'd0);
        check("R3 pc held", 32'(pc_out), 32'(pc_before));
        check("R3 count held", 32'(cnt_out), 32'(cnt_before));
    endtask

    task automatic run_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(res_valid), 32'd0);
        check("R1 taken", 32'(br_taken), 32'd0);
        check("R1 count", 32'(cnt_out), 32'd0);
        check("R1 pc", 32'(pc_out), 32'd0);
        check("R1 cycles", 32'(cyc_count), 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        run_reset();
        run_loop("fwd",          8'h05, 8'h10, 24'h001002, 1'b1);
        run_loop("back",         8'h20, 8'hFE, 24'h004000, 1'b1);
        run_loop("one_falls",    8'h01, 8'h40, 24'h002222, 1'b1);
        run_loop("zero_wraps",   8'h00, 8'h03, 24'h003000, 1'b1);
        run_ignored();
        run_loop("long_wrap_up", 8'h07, 8'h20, 24'hFFFFF0, 1'b1);
        run_loop("long_min",     8'h02, 8'h80, 24'h000010, 1'b1);
        run_loop("short_wrap",   8'h09, 8'h20, 24'h12FFF0, 1'b0);
        run_loop("short_back",   8'h03, 8'h80, 24'h340005, 1'b0);
        run_loop("short_fall",   8'h01, 8'h80, 24'h56FFFF, 1'b0);
        run_ignored();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule